// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the processor status word: five condition flags describing the last ALU result (carry, zero, sign, overflow, equal) and two control bits (interrupt enable and supervisor mode). The ALU hands over a fresh set of condition flags with an update strobe. User code can act on the carry flag directly, by setting, clearing or complementing it, or by copying one selected bit of an operand into it (bit test). Every other change to the word is privileged.

The interrupt-enable bit, the supervisor bit and the whole-word load are accepted only while the supervisor bit is set. A privileged request made in user mode changes nothing in the control bits and raises a one-cycle violation pulse, which a separate exception unit may turn into a trap. The whole word is always visible on a read port, which serves as the store operation. A small condition evaluator lets branch logic test the flags by condition code without addressing the register.

All state is registered on the rising clock edge with a synchronous, active-high reset. The bit-test operand width is a parameter and must be a power of two.

Top module: `pstat_reg`

## Requirements
- R1: The status word has a fixed layout on `word_q`: bit 0 carry, bit 1 zero, bit 2 sign, bit 3 overflow, bit 4 equal, bit 6 interrupt enable, bit 7 supervisor. Bit 5 always reads 0.
- R2: After reset `word_q` is 8'h80: supervisor set, interrupts disabled, all condition flags clear. `priv_fault` is 0.
- R3: When `alu_upd` is high, word bits 4..0 take `alu_cond[4:0]` on the next cycle, with the same bit order as R1. When no update source is active, the flags hold their values.
- R4: `carry_cmd` 2'b01 sets the carry, 2'b10 clears it, 2'b11 complements the current carry and 2'b00 does nothing. These commands work in any mode.
- R5: When `bt_en` is high, the carry takes `bt_operand[bt_index]`.
- R6: For the carry bit the priority is carry command, then bit test, then ALU update. The other ALU flags still update in the same cycle.
- R7: In supervisor mode, `ie_wr_en` writes `ie_wr_val` into bit 6 and `sup_wr_en` writes `sup_wr_val` into bit 7, both visible on the next cycle.
- R8: In user mode (bit 7 = 0), a request on `ie_wr_en`, `sup_wr_en` or `word_load_en` leaves bits 7 and 6 unchanged and performs no load. `priv_fault` is high for exactly the cycle that follows each such refused request.
- R9: In supervisor mode, `word_load_en` replaces the whole word with `word_load_val` (bit 5 forced to 0). This load overrides every other update made in the same cycle.
- R10: `cond_true` is combinational on `cond_sel`: 0 zero, 1 not zero, 2 carry, 3 not carry, 4 sign, 5 overflow, 6 equal, 7 always.
- R11: Carry commands and ALU updates still take effect in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_upd | input | 1 | Load condition flags from the ALU |
| alu_cond | input | 5 | ALU flags {equal, overflow, sign, zero, carry} |
| carry_cmd | input | 2 | Direct carry command |
| bt_en | input | 1 | Bit-test strobe |
| bt_operand | input | OPND_W | Bit-test operand |
| bt_index | input | IDX_W | Bit position tested |
| ie_wr_en | input | 1 | Interrupt-enable write request |
| ie_wr_val | input | 1 | Interrupt-enable value |
| sup_wr_en | input | 1 | Supervisor-bit write request |
| sup_wr_val | input | 1 | Supervisor-bit value |
| word_load_en | input | 1 | Whole-word load request |
| word_load_val | input | 8 | Word to load |
| cond_sel | input | 3 | Branch condition code |
| word_q | output | 8 | Whole status word (store path) |
| cond_true | output | 1 | Selected condition holds |
| supervisor | output | 1 | Current supervisor bit |
| priv_fault | output | 1 | Refused privileged write, one-cycle pulse |

## Verification
The assertions check the following rules on every cycle:
- the reset value;
- the set and clear carry commands;
- the ALU flag load;
- the whole-word load;
- the hold of the control bits under a user-mode request;
- both directions of the link between a refused request and the violation pulse;
- the zero-flag branch condition.

The bench's directed scenarios show what a single-cycle property cannot:
- carry complement against a known history;
- the bit test at chosen bit positions;
- the three-way carry priority;
- the full branch-code table;
- the load overriding other sources;
- unprivileged updates still working after the processor drops to user mode.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

    localparam int WORD_W = 8;
    localparam int COND_W = 5;

    typedef enum logic [1:0] {
        CY_NONE = 2'b00,
        CY_SET  = 2'b01,
        CY_CLR  = 2'b10,
        CY_CPL  = 2'b11
    } carry_op_e;

    typedef enum logic [2:0] {
        BR_Z   = 3'd0,
        BR_NZ  = 3'd1,
        BR_C   = 3'd2,
        BR_NC  = 3'd3,
        BR_S   = 3'd4,
        BR_V   = 3'd5,
        BR_EQ  = 3'd6,
        BR_ALL = 3'd7
    } br_cond_e;

    // Packed MSB first: sup is bit 7, cy is bit 0.
    typedef struct packed {
        logic sup;
        logic ie;
        logic rsv;
        logic eq;
        logic ovf;
        logic sgn;
        logic zero;
        logic cy;
    } pstat_t;

    localparam pstat_t PSTAT_RST = '{sup: 1'b1, default: 1'b0};

    function automatic pstat_t word_to_pstat(input logic [WORD_W-1:0] w);
        pstat_t r;
        r     = pstat_t'(w);
        r.rsv = 1'b0;
        return r;
    endfunction

    function automatic logic carry_after(input carry_op_e op, input logic cur);
        logic r;
        case (op)
            CY_SET:  r = 1'b1;
            CY_CLR:  r = 1'b0;
            CY_CPL:  r = ~cur;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pstat_priv.sv
module pstat_priv
    import pstat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sup_now,
    input  logic ie_wr_en,
    input  logic sup_wr_en,
    input  logic word_load_en,
    output logic ie_ok,
    output logic sup_ok,
    output logic load_ok,
    output logic fault_q
);

    logic any_req;
    logic refused;

    always_comb begin
        any_req = ie_wr_en | sup_wr_en | word_load_en;
        refused = any_req & ~sup_now;
        ie_ok   = ie_wr_en & sup_now;
        sup_ok  = sup_wr_en & sup_now;
        load_ok = word_load_en & sup_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= refused;
        end
    end

endmodule

// File: rtl/pstat_cond_next.sv
module pstat_cond_next
    import pstat_pkg::*;
#(
    parameter  int OPND_W = 32,
    localparam int IDX_W  = $clog2(OPND_W)
) (
    input  logic [COND_W-1:0] cur_cond,
    input  logic              alu_upd,
    input  logic [COND_W-1:0] alu_cond,
    input  carry_op_e         carry_op,
    input  logic              bt_en,
    input  logic [OPND_W-1:0] bt_operand,
    input  logic [IDX_W-1:0]  bt_index,
    output logic [COND_W-1:0] cond_nxt
);

    logic [COND_W-1:0] base;
    logic              bt_bit;

    always_comb begin
        bt_bit = bt_operand[bt_index];
        base   = alu_upd ? alu_cond : cur_cond;
        cond_nxt = base;
        // Carry source priority: direct command, then bit test, then ALU.
        if (carry_op != CY_NONE) begin
            cond_nxt[0] = carry_after(carry_op, cur_cond[0]);
        end else if (bt_en) begin
            cond_nxt[0] = bt_bit;
        end
    end

endmodule

// File: rtl/pstat_branch.sv
module pstat_branch
    import pstat_pkg::*;
(
    input  pstat_t    flags,
    input  br_cond_e  sel,
    output logic      taken
);

    always_comb begin
        case (sel)
            BR_Z:    taken = flags.zero;
            BR_NZ:   taken = ~flags.zero;
            BR_C:    taken = flags.cy;
            BR_NC:   taken = ~flags.cy;
            BR_S:    taken = flags.sgn;
            BR_V:    taken = flags.ovf;
            BR_EQ:   taken = flags.eq;
            default: taken = 1'b1;
        endcase
    end

endmodule

// File: rtl/pstat_reg.sv
module pstat_reg
    import pstat_pkg::*;
#(
    parameter  int OPND_W = 32,
    localparam int IDX_W  = $clog2(OPND_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_upd,
    input  logic [4:0]        alu_cond,
    input  logic [1:0]        carry_cmd,
    input  logic              bt_en,
    input  logic [OPND_W-1:0] bt_operand,
    input  logic [IDX_W-1:0]  bt_index,
    input  logic              ie_wr_en,
    input  logic              ie_wr_val,
    input  logic              sup_wr_en,
    input  logic              sup_wr_val,
    input  logic              word_load_en,
    input  logic [7:0]        word_load_val,
    input  logic [2:0]        cond_sel,
    output logic [7:0]        word_q,
    output logic              cond_true,
    output logic              supervisor,
    output logic              priv_fault
);

    pstat_t            state;
    pstat_t            state_nxt;
    logic [COND_W-1:0] cur_cond;
    logic [COND_W-1:0] cond_nxt;
    logic              ie_ok;
    logic              sup_ok;
    logic              load_ok;

    assign cur_cond = {state.eq, state.ovf, state.sgn, state.zero, state.cy};

    pstat_priv u_priv (
        .clk          (clk),
        .rst          (rst),
        .sup_now      (state.sup),
        .ie_wr_en     (ie_wr_en),
        .sup_wr_en    (sup_wr_en),
        .word_load_en (word_load_en),
        .ie_ok        (ie_ok),
        .sup_ok       (sup_ok),
        .load_ok      (load_ok),
        .fault_q      (priv_fault)
    );

    pstat_cond_next #(.OPND_W(OPND_W)) u_cond (
        .cur_cond   (cur_cond),
        .alu_upd    (alu_upd),
        .alu_cond   (alu_cond),
        .carry_op   (carry_op_e'(carry_cmd)),
        .bt_en      (bt_en),
        .bt_operand (bt_operand),
        .bt_index   (bt_index),
        .cond_nxt   (cond_nxt)
    );

    pstat_branch u_br (
        .flags (state),
        .sel   (br_cond_e'(cond_sel)),
        .taken (cond_true)
    );

    always_comb begin
        state_nxt      = state;
        state_nxt.cy   = cond_nxt[0];
        state_nxt.zero = cond_nxt[1];
        state_nxt.sgn  = cond_nxt[2];
        state_nxt.ovf  = cond_nxt[3];
        state_nxt.eq   = cond_nxt[4];
        if (ie_ok) begin
            state_nxt.ie = ie_wr_val;
        end
        if (sup_ok) begin
            state_nxt.sup = sup_wr_val;
        end
        // A permitted whole-word load overrides all other sources.
        if (load_ok) begin
            state_nxt = word_to_pstat(word_load_val);
        end
        state_nxt.rsv = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PSTAT_RST;
        end else begin
            state <= state_nxt;
        end
    end

    assign word_q     = state;
    assign supervisor = state.sup;

endmodule

// File: rtl/pstat_reg_chk.sv
module pstat_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_upd,
    input logic [4:0] alu_cond,
    input logic [1:0] carry_cmd,
    input logic       ie_wr_en,
    input logic       sup_wr_en,
    input logic       word_load_en,
    input logic [7:0] word_load_val,
    input logic [2:0] cond_sel,
    input logic [7:0] word_q,
    input logic       cond_true,
    input logic       priv_fault
);

    logic priv_req;
    logic load_go;
    assign priv_req = ie_wr_en | sup_wr_en | word_load_en;
    assign load_go  = word_q[7] & word_load_en;

    a_r2_reset_value: assert property (@(posedge clk)
        rst |=> (word_q == 8'h80 && !priv_fault));

    a_r4_set_carry: assert property (@(posedge clk) disable iff (rst)
        (carry_cmd == 2'b01 && !load_go) |=> word_q[0]);

    a_r4_clear_carry: assert property (@(posedge clk) disable iff (rst)
        (carry_cmd == 2'b10 && !load_go) |=> !word_q[0]);

    a_r3_alu_flags: assert property (@(posedge clk) disable iff (rst)
        (alu_upd && !load_go) |=> (word_q[4:1] == $past(alu_cond[4:1])));

    a_r9_word_load: assert property (@(posedge clk) disable iff (rst)
        load_go |=> (word_q == ($past(word_load_val) & 8'hDF)));

    a_r8_user_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        (!word_q[7] && priv_req) |=> $stable(word_q[7:6]));

    a_r8_fault_follows: assert property (@(posedge clk) disable iff (rst)
        (!word_q[7] && priv_req) |=> priv_fault);

    a_r8_fault_cause: assert property (@(posedge clk) disable iff (rst)
        priv_fault |-> $past(!word_q[7] && priv_req));

    a_r10_branch_zero: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == 3'd0) |-> (cond_true == word_q[1]));

endmodule

bind pstat_reg pstat_reg_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .alu_upd       (alu_upd),
    .alu_cond      (alu_cond),
    .carry_cmd     (carry_cmd),
    .ie_wr_en      (ie_wr_en),
    .sup_wr_en     (sup_wr_en),
    .word_load_en  (word_load_en),
    .word_load_val (word_load_val),
    .cond_sel      (cond_sel),
    .word_q        (word_q),
    .cond_true     (cond_true),
    .priv_fault    (priv_fault)
);

// File: tb/pstat_reg_tb_top.sv
module pstat_reg_tb_top;

    localparam int OPND_W = 32;
    localparam int IDX_W  = $clog2(OPND_W);

    logic              clk = 1'b0;
    logic              rst;
    logic              alu_upd;
    logic [4:0]        alu_cond;
    logic [1:0]        carry_cmd;
    logic              bt_en;
    logic [OPND_W-1:0] bt_operand;
    logic [IDX_W-1:0]  bt_index;
    logic              ie_wr_en, ie_wr_val, sup_wr_en, sup_wr_val;
    logic              word_load_en;
    logic [7:0]        word_load_val;
    logic [2:0]        cond_sel;
    logic [7:0]        word_q;
    logic              cond_true, supervisor, priv_fault;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    pstat_reg #(.OPND_W(OPND_W)) dut_i (
        .clk(clk), .rst(rst), .alu_upd(alu_upd), .alu_cond(alu_cond),
        .carry_cmd(carry_cmd), .bt_en(bt_en), .bt_operand(bt_operand),
        .bt_index(bt_index), .ie_wr_en(ie_wr_en), .ie_wr_val(ie_wr_val),
        .sup_wr_en(sup_wr_en), .sup_wr_val(sup_wr_val),
        .word_load_en(word_load_en), .word_load_val(word_load_val),
        .cond_sel(cond_sel), .word_q(word_q), .cond_true(cond_true),
        .supervisor(supervisor), .priv_fault(priv_fault)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_upd = 0; alu_cond = '0; carry_cmd = 2'b00; bt_en = 0;
        bt_operand = '0; bt_index = '0; ie_wr_en = 0; ie_wr_val = 0;
        sup_wr_en = 0; sup_wr_val = 0; word_load_en = 0; word_load_val = '0;
        cond_sel = 3'd7;
    endtask

    // Inputs change 2 time units after a rising edge; results are sampled there too.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        step();
        step();
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R2 reset word", word_q, 8'h80);
        check("R2 reset fault", {7'd0, priv_fault}, 8'h00);
        check("R1 supervisor bit out", {7'd0, supervisor}, 8'h01);
    endtask

    task automatic t_alu();
        do_reset();
        alu_upd = 1; alu_cond = 5'b10110; step(); idle();
        check("R3 alu load", word_q, 8'h96);
        step();
        check("R3 hold without update", word_q, 8'h96);
        alu_upd = 1; alu_cond = 5'b11111; step(); idle();
        check("R1 bit5 reads zero", word_q, 8'h9F);
    endtask

    task automatic t_carry_cmds();
        do_reset();
        alu_upd = 1; alu_cond = 5'b10110; step(); idle();
        carry_cmd = 2'b01; step(); idle();
        check("R4 set carry", word_q, 8'h97);
        carry_cmd = 2'b11; step(); idle();
        check("R4 complement 1->0", word_q, 8'h96);
        carry_cmd = 2'b11; step(); idle();
        check("R4 complement 0->1", word_q, 8'h97);
        carry_cmd = 2'b10; step(); idle();
        check("R4 clear carry", word_q, 8'h96);
    endtask

    task automatic t_bit_test();
        do_reset();
        bt_en = 1; bt_operand = 32'h0000_0100; bt_index = 5'd8; step(); idle();
        check("R5 bit test one", word_q, 8'h81);
        bt_en = 1; bt_operand = 32'h0000_0100; bt_index = 5'd7; step(); idle();
        check("R5 bit test zero", word_q, 8'h80);
        bt_en = 1; bt_operand = 32'h8000_0000; bt_index = 5'd31; step(); idle();
        check("R5 bit test top bit", word_q, 8'h81);
    endtask

    task automatic t_priority();
        do_reset();
        alu_upd = 1; alu_cond = 5'b00011; carry_cmd = 2'b10; step(); idle();
        check("R6 command over alu", word_q, 8'h82);
        bt_en = 1; bt_operand = 32'h1; bt_index = 5'd0; carry_cmd = 2'b10; step(); idle();
        check("R6 command over bit test", word_q, 8'h82);
        alu_upd = 1; alu_cond = 5'b00000; bt_en = 1; bt_operand = 32'h1; bt_index = 5'd0;
        step(); idle();
        check("R6 bit test over alu", word_q, 8'h81);
    endtask

    task automatic t_branch();
        do_reset();
        alu_upd = 1; alu_cond = 5'b10010; step(); idle();   // eq=1 zero=1
        cond_sel = 3'd0; #1; check("R10 zero", {7'd0, cond_true}, 8'h01);
        cond_sel = 3'd1; #1; check("R10 not zero", {7'd0, cond_true}, 8'h00);
        cond_sel = 3'd2; #1; check("R10 carry", {7'd0, cond_true}, 8'h00);
        cond_sel = 3'd3; #1; check("R10 not carry", {7'd0, cond_true}, 8'h01);
        cond_sel = 3'd4; #1; check("R10 sign", {7'd0, cond_true}, 8'h00);
        cond_sel = 3'd5; #1; check("R10 overflow", {7'd0, cond_true}, 8'h00);
        cond_sel = 3'd6; #1; check("R10 equal", {7'd0, cond_true}, 8'h01);
        cond_sel = 3'd7; #1; check("R10 always", {7'd0, cond_true}, 8'h01);
    endtask

    task automatic t_supervisor_writes();
        do_reset();
        ie_wr_en = 1; ie_wr_val = 1; step(); idle();
        check("R7 ie write", word_q, 8'hC0);
        check("R7 no fault", {7'd0, priv_fault}, 8'h00);
        word_load_en = 1; word_load_val = 8'hFF; step(); idle();
        check("R9 load forces bit5 zero", word_q, 8'hDF);
        word_load_en = 1; word_load_val = 8'h81; alu_upd = 1; alu_cond = 5'b11111;
        carry_cmd = 2'b10; ie_wr_en = 1; ie_wr_val = 1; step(); idle();
        check("R9 load overrides others", word_q, 8'h81);
    endtask

    task automatic t_user_mode();
        do_reset();
        sup_wr_en = 1; sup_wr_val = 0; step(); idle();
        check("R7 drop to user", word_q, 8'h00);
        ie_wr_en = 1; ie_wr_val = 1; step(); idle();
        check("R8 ie refused", word_q, 8'h00);
        check("R8 fault pulse", {7'd0, priv_fault}, 8'h01);
        step();
        check("R8 fault one cycle", {7'd0, priv_fault}, 8'h00);
        word_load_en = 1; word_load_val = 8'hFF; step(); idle();
        check("R8 load refused", word_q, 8'h00);
        check("R8 fault on load", {7'd0, priv_fault}, 8'h01);
        sup_wr_en = 1; sup_wr_val = 1; step(); idle();
        check("R8 sup refused", word_q, 8'h00);
        check("R8 fault on sup", {7'd0, priv_fault}, 8'h01);
        carry_cmd = 2'b01; step(); idle();
        check("R11 carry in user mode", word_q, 8'h01);
        check("R11 no fault", {7'd0, priv_fault}, 8'h00);
        alu_upd = 1; alu_cond = 5'b01100; ie_wr_en = 1; ie_wr_val = 1; step(); idle();
        check("R11 alu applies beside refused write", word_q, 8'h0C);
    endtask

    initial begin
        idle();
        rst = 1;
        t_reset();
        t_alu();
        t_carry_cmds();
        t_bit_test();
        t_priority();
        t_branch();
        t_supervisor_writes();
        t_user_mode();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule